// File: doc/BRIEF.md
# H.264 Residual Coefficient Quantizer

This block turns transformed residual coefficients into quantized levels, four signed 16-bit coefficients per beat. A beat carries one row of a 4x4 coefficient block: the row number, the component class of the block (luma or chroma, AC or DC) and an intra/inter flag travel with it. The quantization parameter sits in a small register written from outside. Writes above the legal maximum are clamped.

Each lane avoids division. It takes the magnitude and sign of its coefficient, multiplies the magnitude by a factor chosen from the QP and the coefficient position, adds a rounding offset, shifts right, and puts the sign back. The work is spread over three register stages. A valid flag moves alongside the data, so a new beat can enter on every clock.

Top module: `h264_coef_quant`

## Requirements
- R1: The QP register resets to 0. A write of a value above 51 stores 51, and a write of 0 to 51 stores the value as written.
- R2: A beat accepted on a rising edge with `in_valid` high gives `out_valid` high after exactly three rising edges, for one cycle per beat. Beats may be accepted on consecutive cycles.
- R3: Each output lane equals sign(x) * ((|x| * MF + f) >> s), where x is that lane's input. Lane k occupies bits [16k+15:16k], and a magnitude of 32768 is handled exactly.
- R4: MF is selected by QP mod 6 and a position class. The rows below give position classes 0, 1 and 2:
  - mod 0: 13107, 5243, 8066
  - mod 1: 11916, 4660, 7490
  - mod 2: 10082, 4194, 6554
  - mod 3: 9362, 3647, 5825
  - mod 4: 8192, 3355, 5243
  - mod 5: 7282, 2893, 4559
- R5: The coefficient position is (row = `in_row`, column = lane index). The position class is 0 when both are even, 1 when both are odd, and 2 otherwise.
- R6: `in_cls` encodes 0 = luma AC, 1 = luma DC, 2 = chroma AC, 3 = chroma DC. AC classes shift by s = 15 + floor(QP/6). DC classes (bit 0 set) shift by s = 16 + floor(QP/6) and always use position class 0.
- R7: The rounding offset is f = floor(2^s / 3) when `in_intra` = 1 and f = floor(2^s / 6) when `in_intra` = 0.
- R8: A zero input gives a zero output. A nonzero output has the sign of its input, and its magnitude never exceeds the input magnitude.
- R9: While reset is held, and after it is released, `out_valid` stays low until a beat has been accepted.
- R10: A QP write changes the result only for beats accepted on later edges. A beat accepted on the same edge as the write uses the previous QP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qp_wr | input | 1 | Write strobe for the QP register |
| qp_wdata | input | 6 | QP value to store (clamped to 51) |
| in_valid | input | 1 | Input beat valid |
| in_row | input | 2 | Row of the 4x4 block carried by this beat |
| in_cls | input | 2 | Component class of the block |
| in_intra | input | 1 | 1 selects intra rounding, 0 selects inter rounding |
| in_data | input | 64 | Four signed coefficients, lane 0 in the low bits |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 64 | Four signed quantized levels, same lane order |

## Verification
Some properties are checked on every cycle:
- the stored QP never leaves the legal range;
- a valid beat leaves the pipeline exactly three edges after it enters;
- each lane keeps the sign of its input, maps zero to zero and never grows in magnitude.

The exact arithmetic can only be shown by the bench's sweeps. These cover the factor table entry for every QP residue and position, the different DC shift, the intra and inter offsets, and clamping of out-of-range QP writes. The same holds for the rule that a QP write takes effect on the next beat and not on the beat accepted with it.

// File: rtl/h264q_pkg.sv
package h264q_pkg;

  localparam int QP_MAX_C = 51;
  localparam int MF_W     = 14;

  typedef enum logic [1:0] {
    CLS_LUMA_AC   = 2'd0,
    CLS_LUMA_DC   = 2'd1,
    CLS_CHROMA_AC = 2'd2,
    CLS_CHROMA_DC = 2'd3
  } comp_cls_e;

  // Position class from row and column parity.
  function automatic logic [1:0] pos_class(input logic [1:0] row, input logic [1:0] col);
    if (!row[0] && !col[0])      return 2'd0;
    else if (row[0] && col[0])   return 2'd1;
    else                         return 2'd2;
  endfunction

  // Multiplication factor indexed by QP residue and position class.
  function automatic logic [MF_W-1:0] mf_lookup(input logic [2:0] rem, input logic [1:0] pcls);
    logic [MF_W-1:0] a, b, c;
    case (rem)
      3'd0:    begin a = 14'd13107; b = 14'd5243; c = 14'd8066; end
      3'd1:    begin a = 14'd11916; b = 14'd4660; c = 14'd7490; end
      3'd2:    begin a = 14'd10082; b = 14'd4194; c = 14'd6554; end
      3'd3:    begin a = 14'd9362;  b = 14'd3647; c = 14'd5825; end
      3'd4:    begin a = 14'd8192;  b = 14'd3355; c = 14'd5243; end
      default: begin a = 14'd7282;  b = 14'd2893; c = 14'd4559; end
    endcase
    case (pcls)
      2'd0:    return a;
      2'd1:    return b;
      default: return c;
    endcase
  endfunction

endpackage

// File: rtl/h264q_qp_reg.sv
module h264q_qp_reg #(
  parameter int QPW    = 6,
  parameter int QP_MAX = 51
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [QPW-1:0] wr_qp,
  output logic [QPW-1:0] qp_q,
  output logic [QPW-1:0] qp_div6,
  output logic [QPW-1:0] qp_mod6
);
  localparam logic [QPW-1:0] QP_LIM = QPW'(QP_MAX);
  localparam logic [QPW-1:0] SIX    = QPW'(6);

  logic [QPW-1:0] qp_d;

  always_comb begin
    qp_d = qp_q;
    if (wr_en) qp_d = (wr_qp > QP_LIM) ? QP_LIM : wr_qp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qp_q <= '0;
    else        qp_q <= qp_d;
  end

  always_comb begin
    qp_div6 = qp_q / SIX;
    qp_mod6 = qp_q % SIX;
  end
endmodule

// File: rtl/h264q_lane.sv
module h264q_lane #(
  parameter int CW  = 16,
  parameter int MFW = 14,
  parameter int PW  = 32,
  parameter int SW  = 5
) (
  input  logic           clk,
  input  logic           en0,
  input  logic           en1,
  input  logic           en2,
  input  logic [CW-1:0]  sample,
  input  logic [MFW-1:0] mf,
  input  logic [SW-1:0]  shift,
  input  logic [PW-1:0]  offset,
  output logic [CW-1:0]  result
);
  logic [CW-1:0]  mag_d, mag_q;
  logic           sgn_q, sgn2_q;
  logic [MFW-1:0] mf_q;
  logic [PW-1:0]  prod_d, prod_q, sum;
  logic [CW-1:0]  z, res_d, res_q;

  // stage 1: magnitude and sign split
  always_comb mag_d = sample[CW-1] ? (~sample + 1'b1) : sample;
  // stage 2: multiply
  always_comb prod_d = PW'(mag_q) * PW'(mf_q);
  // stage 3: round, shift, sign back
  always_comb begin
    sum   = prod_q + offset;
    z     = CW'(sum >> shift);
    res_d = sgn2_q ? (~z + 1'b1) : z;
  end

  always_ff @(posedge clk) begin
    if (en0) begin
      mag_q <= mag_d;
      sgn_q <= sample[CW-1];
      mf_q  <= mf;
    end
    if (en1) begin
      prod_q <= prod_d;
      sgn2_q <= sgn_q;
    end
    if (en2) res_q <= res_d;
  end

  assign result = res_q;
endmodule

// File: rtl/h264_coef_quant.sv
module h264_coef_quant
  import h264q_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CW    = 16,
  parameter int QPW   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                qp_wr,
  input  logic [QPW-1:0]      qp_wdata,
  input  logic                in_valid,
  input  logic [1:0]          in_row,
  input  logic [1:0]          in_cls,
  input  logic                in_intra,
  input  logic [LANES*CW-1:0] in_data,
  output logic                out_valid,
  output logic [LANES*CW-1:0] out_data
);
  localparam int PW      = 32;
  localparam int SW      = 5;
  localparam int BASE_SH = 15;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta} <= 2'b00;
    else        {rst_sync_n, rst_meta} <= {rst_meta, 1'b1};
  end

  logic [QPW-1:0] qp_q, qp_div6, qp_mod6;
  h264q_qp_reg #(.QPW(QPW), .QP_MAX(QP_MAX_C)) u_qp (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(qp_wr), .wr_qp(qp_wdata),
    .qp_q(qp_q), .qp_div6(qp_div6), .qp_mod6(qp_mod6)
  );

  // stage-0 control: shift and offset shared by all lanes
  logic          is_dc;
  logic [SW-1:0] shift0;
  logic [PW-1:0] pow0, off0;
  always_comb begin
    is_dc  = in_cls[0];
    shift0 = SW'(BASE_SH) + SW'(qp_div6) + SW'(is_dc);
    pow0   = PW'(1) << shift0;
    off0   = in_intra ? (pow0 / PW'(3)) : (pow0 / PW'(6));
  end

  // valid pipeline
  logic       v1_q, v2_q, v3_q;
  logic [2:0] v_d;
  always_comb v_d = {v2_q, v1_q, in_valid};
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) {v3_q, v2_q, v1_q} <= 3'b000;
    else             {v3_q, v2_q, v1_q} <= v_d;
  end

  // control pipeline, aligned with lane stage 3
  logic [SW-1:0] s1_shift, s2_shift;
  logic [PW-1:0] s1_off, s2_off;
  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_shift <= shift0;
      s1_off   <= off0;
    end
    if (v1_q) begin
      s2_shift <= s1_shift;
      s2_off   <= s1_off;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [MF_W-1:0] mf_g;
    always_comb mf_g = mf_lookup(qp_mod6[2:0],
                                 is_dc ? 2'd0 : pos_class(in_row, 2'(g)));
    h264q_lane #(.CW(CW), .MFW(MF_W), .PW(PW), .SW(SW)) u_lane (
      .clk(clk), .en0(in_valid), .en1(v1_q), .en2(v2_q),
      .sample(in_data[g*CW +: CW]), .mf(mf_g),
      .shift(s2_shift), .offset(s2_off),
      .result(out_data[g*CW +: CW])
    );
  end

  assign out_valid = v3_q;
endmodule

// File: rtl/h264q_checks.sv
module h264q_checks #(
  parameter int LANES = 4,
  parameter int CW    = 16,
  parameter int QPW   = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [LANES*CW-1:0] in_data,
  input logic                out_valid,
  input logic [LANES*CW-1:0] out_data,
  input logic [QPW-1:0]      qp_q
);
  function automatic logic [CW:0] absval(input logic [CW-1:0] v);
    return v[CW-1] ? ({1'b0, ~v} + 1'b1) : {1'b0, v};
  endfunction

  a_r1_qp_range: assert property (@(posedge clk) disable iff (!rst_n)
    qp_q <= QPW'(51));

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 3));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    a_r8_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_data[g*CW +: CW] != '0) |->
        out_data[g*CW+CW-1] == $past(in_data[g*CW+CW-1], 3));

    a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(in_data[g*CW +: CW], 3) == '0) |->
        out_data[g*CW +: CW] == '0);

    a_r8_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |->
        absval(out_data[g*CW +: CW]) <= absval($past(in_data[g*CW +: CW], 3)));
  end
endmodule

bind h264_coef_quant h264q_checks #(.LANES(LANES), .CW(CW), .QPW(QPW)) u_checks (
  .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data), .qp_q(qp_q)
);

// File: tb/tb_h264_coef_quant.sv
module tb_h264_coef_quant;
  localparam int LANES = 4;
  localparam int CW    = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                rst_n, qp_wr, in_valid, in_intra, out_valid;
  logic [5:0]          qp_wdata;
  logic [1:0]          in_row, in_cls;
  logic [LANES*CW-1:0] in_data, out_data;

  h264_coef_quant dut (
    .clk(clk), .rst_n(rst_n), .qp_wr(qp_wr), .qp_wdata(qp_wdata),
    .in_valid(in_valid), .in_row(in_row), .in_cls(in_cls), .in_intra(in_intra),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int qp_model = 0;

  function automatic int mf_ref(int rem, int pc);
    int t[6][3] = '{'{13107, 5243, 8066}, '{11916, 4660, 7490}, '{10082, 4194, 6554},
                    '{9362, 3647, 5825},  '{8192, 3355, 5243},  '{7282, 2893, 4559}};
    return t[rem][pc];
  endfunction

  function automatic logic [15:0] ref_q(int qp, int cls, int row, int col, bit intra,
                                        logic signed [15:0] x);
    int pc, s;
    longint mag, z, f;
    if (cls % 2 == 1)                        pc = 0;
    else if (row % 2 == 0 && col % 2 == 0)   pc = 0;
    else if (row % 2 == 1 && col % 2 == 1)   pc = 1;
    else                                     pc = 2;
    s   = 15 + qp / 6 + cls % 2;
    f   = (longint'(1) << s) / (intra ? 3 : 6);
    mag = (x < 0) ? -longint'(x) : longint'(x);
    z   = (mag * mf_ref(qp % 6, pc) + f) >> s;
    return (x < 0) ? 16'(-z) : 16'(z);
  endfunction

  function automatic logic [15:0] sample_val(int n, int l);
    int seed = n * 4 + l;
    int v    = seed * 40503 + 12345;
    case (seed % 13)
      0: return 16'h8000;
      1: return 16'h7fff;
      2: return 16'h0000;
      3: return 16'hffff;
      4: return 16'h0001;
      default: return v[15:0];
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d (0x%h) expected %0d (0x%h)", req,
               $signed(got), got, $signed(exp), exp);
    end
  endtask

  task automatic write_qp(int v);
    @(negedge clk);
    qp_wr = 1'b1; qp_wdata = 6'(v);
    @(negedge clk);
    qp_wr = 1'b0;
    qp_model = (v > 51) ? 51 : v;
  endtask

  task automatic drive_beat(int cls, int row, bit intra, int n);
    in_valid = 1'b1; in_cls = 2'(cls); in_row = 2'(row); in_intra = intra;
    for (int l = 0; l < LANES; l++) in_data[l*CW +: CW] = sample_val(n, l);
  endtask

  task automatic check_lanes(string req, int qp, int cls, int row, bit intra, int n);
    for (int l = 0; l < LANES; l++) begin
      logic [15:0] e;
      e = ref_q(qp, cls, row, l, intra, sample_val(n, l));
      chk(req, out_data[l*CW +: CW], e);
      if (e != 16'd0)
        chk("R8 sign", 16'(out_data[l*CW+CW-1]), 16'(sample_val(n, l) >> 15));
    end
  endtask

  task automatic run_beat(string req, int cls, int row, bit intra, int n);
    @(negedge clk);
    drive_beat(cls, row, intra, n);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R2 early", 16'(out_valid), 16'd0);
    @(negedge clk);
    chk("R2 valid", 16'(out_valid), 16'd1);
    check_lanes(req, qp_model, cls, row, intra, n);
    @(negedge clk);
    chk("R2 single", 16'(out_valid), 16'd0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int n = 0;
    int qp_used[6];
    rst_n = 1'b0; qp_wr = 1'b0; qp_wdata = '0; in_valid = 1'b0;
    in_row = '0; in_cls = '0; in_intra = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    chk("R9 in reset", 16'(out_valid), 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 after reset", 16'(out_valid), 16'd0);

    // R1: QP resets to zero
    run_beat("R1 reset QP", 0, 1, 1'b1, n++);
    run_beat("R1 reset QP DC", 1, 0, 1'b0, n++);

    // sweep: QP 0..53 (52 and 53 clamp, R1), all classes, rows, rounding modes
    for (int q = 0; q < 54; q++) begin
      write_qp(q);
      for (int c = 0; c < 4; c++)
        for (int it = 0; it < 2; it++)
          for (int r = 0; r < 4; r++)
            run_beat((q > 51) ? "R1 clamp R3" : "R3 R4 R5 R6 R7", c, r, it[0], n++);
    end
    write_qp(63);
    run_beat("R1 clamp 63", 2, 3, 1'b1, n++);

    // back-to-back beats, QP write on the edge of beat 2 (R2, R10)
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      if (t >= 3 && t < 9) begin
        chk("R2 stream valid", 16'(out_valid), 16'd1);
        check_lanes("R10 R2 stream", qp_used[t-3], (t-3) % 4, (t-3) % 4, (t-3) % 2 == 1,
                    n + t - 3);
      end
      if (t == 9) chk("R2 stream end", 16'(out_valid), 16'd0);
      if (t < 6) begin
        drive_beat(t % 4, t % 4, t % 2 == 1, n + t);
        qp_used[t] = (t <= 2) ? 51 : 10;
      end else begin
        in_valid = 1'b0;
      end
      qp_wr    = (t == 2);
      qp_wdata = 6'd10;
    end
    qp_wr = 1'b0;
    finish_run();
  end
endmodule